// File: doc/BRIEF.md
# Pulse Accumulator with Timer Clock Selection

This block counts activity on a single external input pin in a 16-bit accumulator. It has two modes. In event mode it counts one chosen edge direction of the pin. In gated mode it counts a divide-by-64 tick from the timer prescaler, but only while the pin sits at a chosen level. It keeps an input-edge flag and an overflow flag. Each flag is cleared by writing 1 to it, and each flag drives its own interrupt request through a separate enable.

The block also chooses the clock pulse that advances the main timer counter. The choices are the prescaler tick, the accumulator's own count pulse, or that pulse divided by 256 or by 65536. Software writes a 7-bit control word, can load the count, and clears flags through write strobes.

Top module: `pacc_top`

## Requirements
- R1: After reset the count is 0, both flags and both interrupt requests are 0, and the control word is 0: the block is disabled and `tcnt_tick` follows `presc_tick`.
- R2: Control bit 0 enables the accumulator. While it is 0 the count never changes on pin activity. Event mode counts whatever the value of `tmr_en`.
- R3: Control bit 1 selects the mode: 0 is event mode, 1 is gated mode. In event mode, control bit 2 = 0 counts falling edges and bit 2 = 1 counts rising edges. Each edge of the pin counts exactly once. The pin passes through a two-flop synchronizer, so the count changes on the third rising clock edge after the pin changes.
- R4: In gated mode, each cycle with `e64_tick` high adds 1 to the count, as long as the synchronized pin is at the active level. The active level is high when control bit 2 = 0 and low when bit 2 = 1. Ticks at the inactive level add nothing.
- R5: In gated mode nothing is counted while `tmr_en` is 0.
- R6: The edge flag is `flags[0]`. It sets on the edge polarity picked by control bit 2: falling when bit 2 = 0, rising when bit 2 = 1. In event mode this is the counted edge. In gated mode it is the trailing edge that closes the active level.
- R7: The overflow flag is `flags[1]`. A count step from 0xFFFF to 0x0000 sets it.
- R8: A write with `flg_clr_we` clears each flag whose `flg_clr` bit is 1 (bit 0 is the edge flag, bit 1 is the overflow flag). A flag that is set in the same cycle stays set.
- R9: `irq_ovf` is high exactly when the overflow flag and control bit 5 are both 1. `irq_edge` is high exactly when the edge flag and control bit 6 are both 1.
- R10: While enabled, control bits 4:3 select the source of `tcnt_tick`: 00 is the prescaler tick, 01 is the accumulator count pulse, 10 is the /256 tap, and 11 is the /65536 tap. The new choice applies from the cycle after the control write.
- R11: While control bit 0 is 0, `tcnt_tick` equals `presc_tick` whatever bits 4:3 hold.
- R12: The /256 tap pulses together with every 256th accumulator count pulse counted from reset. The /65536 tap pulses with every 65536th.
- R13: `cnt_we` loads `cnt_wdata` into the count. When a load and a count pulse fall in the same cycle, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | External accumulator input, asynchronous |
| tmr_en | input | 1 | Main timer enable; gates the divide-by-64 tick |
| presc_tick | input | 1 | Timer prescaler clock pulse |
| e64_tick | input | 1 | Divide-by-64 tick from the prescaler |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 7 | Control word: en, mode, polarity, select[1:0], ovf ie, edge ie (bit 0 upward) |
| cnt_we | input | 1 | Count load strobe |
| cnt_wdata | input | 16 | Count load value |
| flg_clr_we | input | 1 | Flag clear strobe |
| flg_clr | input | 2 | Write-1-to-clear mask (bit 0 edge, bit 1 overflow) |
| count | output | 16 | Accumulator value |
| flags | output | 2 | Edge flag (bit 0), overflow flag (bit 1) |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_edge | output | 1 | Input-edge interrupt request |
| tcnt_tick | output | 1 | Clock pulse for the main timer counter |

## Verification
The hardest case to reach is the /65536 tap. It fires only after 65536 accumulator pulses since reset, and the divider cannot be loaded. The bench resets the block and sets up gated mode with the pin held at its active level. It then holds `e64_tick` high for 65536 consecutive cycles, and the accumulator wraps at the same moment. The bench counts `tcnt_tick` pulses and checks the wrap flag. The /256 tap is reached the same way over 512 cycles, and the cycle of its first pulse is checked.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

   typedef enum logic [1:0] {
      SEL_PRESC  = 2'b00,
      SEL_ACC    = 2'b01,
      SEL_DIV_LO = 2'b10,
      SEL_DIV_HI = 2'b11
   } clk_sel_e;

   // bit 0 upward: enable, gated, edge_pol, clk_sel[1:0], ovf_ie, edge_ie
   typedef struct packed {
      logic     edge_ie;
      logic     ovf_ie;
      clk_sel_e clk_sel;
      logic     edge_pol;
      logic     gated;
      logic     enable;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
   parameter int SYNC_N = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic lvl,
   output logic rise,
   output logic fall
);

   generate
      if (SYNC_N < 2) begin : g_bad_sync
         $error("pacc_sync: SYNC_N must be at least 2");
      end
   endgenerate

   logic [SYNC_N-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[SYNC_N-2:0], pin};
         prev_q  <= chain_q[SYNC_N-1];
      end
   end

   assign lvl  = chain_q[SYNC_N-1];
   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;

   // R3: an edge is reported for one cycle only
   p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
   p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);

endmodule

// File: rtl/pacc_core.sv
module pacc_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             gated,
   input  logic             edge_pol,
   input  logic             tmr_en,
   input  logic             e64_tick,
   input  logic             lvl,
   input  logic             rise,
   input  logic             fall,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             flg_clr_we,
   input  logic [1:0]       flg_clr,
   output logic [CNT_W-1:0] count,
   output logic             edge_flag,
   output logic             ovf_flag,
   output logic             acc_pulse
);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("pacc_core: CNT_W must be at least 2");
      end
   endgenerate

   logic sel_edge, gate_open, wrap;

   // The counted edge in event mode and the trailing edge in gated mode
   // have the same polarity, so one select serves both.
   assign sel_edge  = edge_pol ? rise : fall;
   assign gate_open = edge_pol ? ~lvl : lvl;
   assign acc_pulse = enable & (gated ? (tmr_en & e64_tick & gate_open) : sel_edge);
   assign wrap      = acc_pulse & (&count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count     <= '0;
         edge_flag <= 1'b0;
         ovf_flag  <= 1'b0;
      end else begin
         if (cnt_we)
            count <= cnt_wdata;
         else if (acc_pulse)
            count <= count + 1'b1;
         edge_flag <= (enable & sel_edge) | (edge_flag & ~(flg_clr_we & flg_clr[0]));
         ovf_flag  <= (wrap & ~cnt_we) | (ovf_flag & ~(flg_clr_we & flg_clr[1]));
      end
   end

   p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_pulse && !cnt_we) |=> count == CNT_W'($past(count) + 1'b1));
   p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_pulse && !cnt_we) |=> $stable(count));
   p_gate_timer_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (gated && !tmr_en && !cnt_we) |=> $stable(count));
   p_ovf_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> count == '0);
   p_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> count == $past(cnt_wdata));

endmodule

// File: rtl/pacc_clkmux.sv
module pacc_clkmux
   import pacc_pkg::*;
#(
   parameter int DIV_LO = 8,
   parameter int DIV_HI = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     enable,
   input  clk_sel_e sel,
   input  logic     acc_pulse,
   input  logic     presc_tick,
   output logic     tcnt_tick
);

   generate
      if (DIV_LO < 1 || DIV_LO >= DIV_HI) begin : g_bad_div
         $error("pacc_clkmux: need 1 <= DIV_LO < DIV_HI");
      end
   endgenerate

   logic [DIV_HI-1:0] div_q;
   logic              tap_lo, tap_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_q <= '0;
      else if (acc_pulse)
         div_q <= div_q + 1'b1;
   end

   assign tap_lo = acc_pulse & (&div_q[DIV_LO-1:0]);
   assign tap_hi = acc_pulse & (&div_q);

   always_comb begin
      if (!enable)
         tcnt_tick = presc_tick;
      else begin
         unique case (sel)
            SEL_PRESC:  tcnt_tick = presc_tick;
            SEL_ACC:    tcnt_tick = acc_pulse;
            SEL_DIV_LO: tcnt_tick = tap_lo;
            SEL_DIV_HI: tcnt_tick = tap_hi;
            default:    tcnt_tick = presc_tick;
         endcase
      end
   end

   // R12: the slow tap always coincides with a fast tap
   p_tap_nest_r12: assert property (@(posedge clk) disable iff (!rst_n)
      tap_hi |-> tap_lo);
   p_tap_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
      tap_lo |=> div_q[DIV_LO-1:0] == '0);

endmodule

// File: rtl/pacc_top.sv
module pacc_top
   import pacc_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int SYNC_N = 2,
   parameter int DIV_LO = 8,
   parameter int DIV_HI = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_in,
   input  logic             tmr_en,
   input  logic             presc_tick,
   input  logic             e64_tick,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             flg_clr_we,
   input  logic [1:0]       flg_clr,
   output logic [CNT_W-1:0] count,
   output logic [1:0]       flags,
   output logic             irq_ovf,
   output logic             irq_edge,
   output logic             tcnt_tick
);

   ctl_t ctl_q;
   logic lvl, rise, fall, acc_pulse, edge_flag, ovf_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (ctl_we)
         ctl_q <= ctl_t'(ctl_wdata);
   end

   pacc_sync #(.SYNC_N(SYNC_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(pin_in),
      .lvl(lvl), .rise(rise), .fall(fall)
   );

   pacc_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n),
      .enable(ctl_q.enable), .gated(ctl_q.gated), .edge_pol(ctl_q.edge_pol),
      .tmr_en(tmr_en), .e64_tick(e64_tick),
      .lvl(lvl), .rise(rise), .fall(fall),
      .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
      .flg_clr_we(flg_clr_we), .flg_clr(flg_clr),
      .count(count), .edge_flag(edge_flag), .ovf_flag(ovf_flag),
      .acc_pulse(acc_pulse)
   );

   pacc_clkmux #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_mux (
      .clk(clk), .rst_n(rst_n), .enable(ctl_q.enable), .sel(ctl_q.clk_sel),
      .acc_pulse(acc_pulse), .presc_tick(presc_tick), .tcnt_tick(tcnt_tick)
   );

   assign flags    = {ovf_flag, edge_flag};
   assign irq_ovf  = ovf_flag & ctl_q.ovf_ie;
   assign irq_edge = edge_flag & ctl_q.edge_ie;

   p_disabled_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q.enable && !cnt_we) |=> $stable(count));
   p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_clr_we && flg_clr[0] && !rise && !fall) |=> !flags[0]);

endmodule

// File: tb/pacc_top_test.sv
module pacc_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin_in = 1'b0, tmr_en = 1'b1, presc_tick = 1'b0, e64_tick = 1'b0;
   logic        ctl_we = 1'b0, cnt_we = 1'b0, flg_clr_we = 1'b0;
   logic [6:0]  ctl_wdata = '0;
   logic [15:0] cnt_wdata = '0;
   logic [1:0]  flg_clr = '0;
   logic [15:0] count;
   logic [1:0]  flags;
   logic        irq_ovf, irq_edge, tcnt_tick;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pacc_top uut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tmr_en(tmr_en),
      .presc_tick(presc_tick), .e64_tick(e64_tick),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
      .flg_clr_we(flg_clr_we), .flg_clr(flg_clr),
      .count(count), .flags(flags), .irq_ovf(irq_ovf), .irq_edge(irq_edge),
      .tcnt_tick(tcnt_tick)
   );

   // vector: gated mode, polarity, pulses/ticks; expected count = n
   typedef struct packed { logic gated; logic pol; logic [7:0] n; } vec_t;
   localparam int NV = 7;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b0, 8'd5}, '{1'b0, 1'b1, 8'd3}, '{1'b0, 1'b0, 8'd0},
      '{1'b1, 1'b0, 8'd7}, '{1'b1, 1'b1, 8'd4}, '{1'b0, 1'b1, 8'd1},
      '{1'b1, 1'b0, 8'd1}
   };

   function automatic logic [6:0] mk(input logic en, input logic g, input logic pol,
                                     input logic [1:0] sel, input logic oie, input logic eie);
      return {eie, oie, sel, pol, g, en};
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_ctl(input logic [6:0] v);
      ctl_wdata = v; ctl_we = 1'b1; cyc(1); ctl_we = 1'b0;
   endtask

   task automatic load(input logic [15:0] v);
      cnt_wdata = v; cnt_we = 1'b1; cyc(1); cnt_we = 1'b0;
   endtask

   task automatic clr(input logic [1:0] m);
      flg_clr = m; flg_clr_we = 1'b1; cyc(1); flg_clr_we = 1'b0;
   endtask

   task automatic pulse_pin;
      pin_in = 1'b1; cyc(4); pin_in = 1'b0; cyc(4);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         e64_tick = 1'b1; cyc(1); e64_tick = 1'b0; cyc(1);
      end
   endtask

   task automatic do_reset;
      rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int taps;
      int first;
      @(negedge clk);
      do_reset();

      // R1 reset state
      chk("R1 count", count, 0);
      chk("R1 flags", flags, 0);
      chk("R1 irqs", {irq_ovf, irq_edge}, 0);
      presc_tick = 1'b1; #1 chk("R1 tcnt follows presc", tcnt_tick, 1);
      presc_tick = 1'b0; #1 chk("R1 tcnt follows presc low", tcnt_tick, 0);
      @(negedge clk);

      // vector table walk: R3 R4 R6
      for (int v = 0; v < NV; v++) begin
         wr_ctl(mk(1'b0, VEC[v].gated, VEC[v].pol, 2'b00, 1'b0, 1'b0));
         pin_in = VEC[v].gated ? VEC[v].pol : 1'b0;
         cyc(4);
         load(16'h0000);
         clr(2'b11);
         wr_ctl(mk(1'b1, VEC[v].gated, VEC[v].pol, 2'b00, 1'b0, 1'b0));
         if (!VEC[v].gated) begin
            for (int p = 0; p < int'(VEC[v].n); p++) pulse_pin();
         end else begin
            pin_in = ~VEC[v].pol; cyc(4);
            ticks(int'(VEC[v].n));
            pin_in = VEC[v].pol; cyc(4);
            ticks(3); // inactive level: R4 no count
         end
         chk(VEC[v].gated ? "R4 gated count" : "R3 event count", count, {24'd0, VEC[v].n});
         chk("R6 edge flag", flags[0], (VEC[v].gated || VEC[v].n != 0) ? 1 : 0);
      end

      // R2 disabled: pin activity ignored
      do_reset();
      pulse_pin(); pulse_pin();
      chk("R2 disabled no count", count, 0);
      chk("R2 disabled no flag", flags[0], 0);
      // R2 event mode counts with timer off
      tmr_en = 1'b0;
      wr_ctl(mk(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0));
      pulse_pin(); pulse_pin();
      chk("R2 event independent of tmr_en", count, 2);

      // R5 gated with timer off
      wr_ctl(mk(1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0));
      load(16'h0000);
      pin_in = 1'b1; cyc(4);
      ticks(5);
      chk("R5 gated needs tmr_en", count, 0);
      tmr_en = 1'b1;
      ticks(2);
      chk("R5 gated counts with tmr_en", count, 2);

      // R11 disabled forces prescaler
      wr_ctl(mk(1'b0, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0));
      e64_tick = 1'b1; presc_tick = 1'b0; #1
      chk("R11 disabled ignores select", tcnt_tick, 0);
      presc_tick = 1'b1; #1
      chk("R11 disabled passes presc", tcnt_tick, 1);
      @(negedge clk);

      // R10 select (pin high, ticks held high, gated)
      presc_tick = 1'b0;
      wr_ctl(mk(1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0));
      #1 chk("R10 sel 01 acc pulse", tcnt_tick, 1);
      @(negedge clk);
      wr_ctl(mk(1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0));
      #1 chk("R10 sel 00 presc low", tcnt_tick, 0);
      presc_tick = 1'b1; #1 chk("R10 sel 00 presc high", tcnt_tick, 1);
      presc_tick = 1'b0;
      @(negedge clk);

      // R13 load beats a simultaneous count
      cnt_wdata = 16'h1234; cnt_we = 1'b1; cyc(1);
      cnt_we = 1'b0; e64_tick = 1'b0;
      chk("R13 load priority", count, 16'h1234);

      // R7 R9 overflow
      clr(2'b11);
      load(16'hFFFF);
      ticks(1);
      chk("R7 wrap to zero", count, 0);
      chk("R7 ovf flag", flags[1], 1);
      chk("R9 irq_ovf masked", irq_ovf, 0);
      wr_ctl(mk(1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0));
      chk("R9 irq_ovf enabled", irq_ovf, 1);
      clr(2'b10);
      chk("R8 ovf cleared", flags[1], 0);
      chk("R9 irq_ovf after clear", irq_ovf, 0);
      // R8 set wins over clear
      load(16'hFFFF);
      e64_tick = 1'b1; flg_clr = 2'b10; flg_clr_we = 1'b1; cyc(1);
      e64_tick = 1'b0; flg_clr_we = 1'b0;
      chk("R8 set beats clear", flags[1], 1);
      // R6 R9 edge interrupt
      wr_ctl(mk(1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1));
      pin_in = 1'b0; cyc(4);
      chk("R9 irq_edge on trailing edge", irq_edge, 1);
      clr(2'b01);
      chk("R8 edge cleared", {flags[0], irq_edge}, 0);

      // R12 /256 tap
      pin_in = 1'b1;
      do_reset();
      cyc(4);
      wr_ctl(mk(1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0));
      taps = 0; first = -1;
      e64_tick = 1'b1;
      for (int k = 0; k < 512; k++) begin
         #1 if (tcnt_tick) begin taps++; if (first < 0) first = k; end
         @(negedge clk);
      end
      e64_tick = 1'b0;
      chk("R12 div256 pulses", taps, 2);
      chk("R12 div256 first at 256th", first, 255);

      // R12 /65536 tap and R7 wrap
      do_reset();
      cyc(4);
      wr_ctl(mk(1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0));
      taps = 0; first = -1;
      e64_tick = 1'b1;
      for (int k = 0; k < 65536; k++) begin
         #1 if (tcnt_tick) begin taps++; if (first < 0) first = k; end
         @(negedge clk);
      end
      e64_tick = 1'b0;
      chk("R12 div65536 pulses", taps, 1);
      chk("R12 div65536 position", first, 65535);
      chk("R7 long run wrap", {flags[1], count}, {1'b1, 16'h0000});

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule